// File: doc/BRIEF.md
# Segmented Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical address. It holds four segment bases, one each for code, data, stack and extra accesses. The base picked by the access type is shifted left by four bits and added to the offset, so every segment covers 64 KB and starts on a 16-byte boundary. A sum that passes FFFFF wraps back to the bottom of the 1 MB space.

The block also holds the instruction pointer. Code accesses use the instruction pointer as the offset, and stack accesses use the stack pointer. Data and extra accesses take one of three offsets: a direct value, an index register value or the stack pointer. After each fetch, the instruction pointer moves forward by the length of the fetched instruction. The physical address is a combinational function of the stored state and the current inputs. The segment bases and the instruction pointer change only on a clock edge.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, the code base is FFFF and the instruction pointer is 0000, so a code access gives FFFF0. The data, stack and extra bases are 0000.
- R2: With access type 0 (code), phys_addr = (code base << 4) + instruction pointer. Example: base 1234 with IP 0012 gives 12352.
- R3: With access type 1 (data), phys_addr = (data base << 4) + offset. The offset comes from ofs_src: 0 selects ofs_direct, 1 selects ofs_index, and 2 or 3 select sp_val. Example: with base 1234, offset 0300 gives 12640 and 0310 gives 12650.
- R4: With access type 2 (stack), phys_addr = (stack base << 4) + sp_val, whatever ofs_src holds.
- R5: With access type 3 (extra), phys_addr = (extra base << 4) + the offset selected by ofs_src, using the same encoding as R3.
- R6: The address sum wraps modulo 2^20. Example: base FFFF with offset FFFF gives 0FFEF.
- R7: When ip_adv is high at a clock edge, the instruction pointer becomes IP + ilen, modulo 2^16. Example: a length of 2 at 0012 leaves 0014.
- R8: When ip_adv is low at a clock edge, the instruction pointer keeps its value.
- R9: When seg_we is high at a clock edge, the base selected by seg_sel takes seg_wdata and the other bases keep their values. seg_sel uses the same codes as the access type (0 code, 1 data, 2 stack, 3 extra). When seg_we is low, no base changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment base write strobe |
| seg_sel | input | 2 | Segment base to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | New segment base value |
| acc_type | input | 2 | Access type (0 code, 1 data, 2 stack, 3 extra) |
| ofs_src | input | 2 | Offset source for data/extra (0 direct, 1 index, 2/3 stack pointer) |
| ofs_direct | input | 16 | Direct offset value |
| ofs_index | input | 16 | Index register value |
| sp_val | input | 16 | Stack pointer value |
| ilen | input | 3 | Length in bytes of the fetched instruction |
| ip_adv | input | 1 | Advance the instruction pointer by ilen |
| phys_addr | output | 20 | 20-bit physical address |
| ip_out | output | 16 | Current instruction pointer |

## Verification
A segment base that is wrong, or written into the wrong slot, shows up at phys_addr at the next access of that type. The error is a multiple of 16, so the low nibble of the address still matches the offset. A missed or doubled instruction-pointer step shows up at ip_out on the cycle right after the edge. It stays there, because every later value is built on the stored pointer. An error in the offset select or in the wrap shows up in the same cycle as the access, with no latency. The bench therefore compares both outputs on every cycle, so any fault is caught on the first cycle it can be seen.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int OW      = 16,
  parameter int SHIFT   = 4,
  parameter int LW      = 3,
  parameter int NSEG    = 4,
  parameter int CODE_RST = (1 << OW) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seg_we,
  input  logic [1:0]            seg_sel,
  input  logic [OW-1:0]         seg_wdata,
  input  logic [1:0]            acc_type,
  input  logic [1:0]            ofs_src,
  input  logic [OW-1:0]         ofs_direct,
  input  logic [OW-1:0]         ofs_index,
  input  logic [OW-1:0]         sp_val,
  input  logic [LW-1:0]         ilen,
  input  logic                  ip_adv,
  output logic [OW+SHIFT-1:0]   phys_addr,
  output logic [OW-1:0]         ip_out
);
  localparam int AW = OW + SHIFT;
  localparam logic [1:0] ACC_CODE  = 2'd0;
  localparam logic [1:0] ACC_STACK = 2'd2;

  logic [OW-1:0] seg_q [NSEG];
  logic [OW-1:0] ip_q;
  logic [OW-1:0] ofs;
  logic [OW-1:0] seg_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++)
        seg_q[i] <= (i == 0) ? OW'(CODE_RST) : '0;
    end else if (seg_we) begin
      seg_q[seg_sel] <= seg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ip_q <= '0;
    else if (ip_adv) ip_q <= ip_q + OW'(ilen);
  end

  always_comb begin
    if (acc_type == ACC_CODE)       ofs = ip_q;
    else if (acc_type == ACC_STACK) ofs = sp_val;
    else begin
      case (ofs_src)
        2'd0:    ofs = ofs_direct;
        2'd1:    ofs = ofs_index;
        default: ofs = sp_val;
      endcase
    end
  end

  assign seg_cur   = seg_q[acc_type];
  assign phys_addr = (AW'(seg_cur) << SHIFT) + AW'(ofs);
  assign ip_out    = ip_q;

  AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ip_adv |=> ip_out == OW'($past(ip_out) + OW'($past(ilen)))); // R7
  AST_IP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ip_adv |=> $stable(ip_out)); // R8
  AST_CODE_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type == ACC_CODE |-> phys_addr[SHIFT-1:0] == ip_out[SHIFT-1:0]); // R2
  AST_STACK_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_type == ACC_STACK |-> phys_addr[SHIFT-1:0] == sp_val[SHIFT-1:0]); // R4

  for (genvar g = 0; g < NSEG; g++) begin : g_seg_chk
    AST_SEG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(seg_we && seg_sel == 2'(g)) |=> $stable(seg_q[g])); // R9
    AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_we && seg_sel == 2'(g)) |=> seg_q[g] == $past(seg_wdata)); // R9
  end
endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        seg_we = 0;
  logic [1:0]  seg_sel = 0;
  logic [15:0] seg_wdata = 0;
  logic [1:0]  acc_type = 0;
  logic [1:0]  ofs_src = 0;
  logic [15:0] ofs_direct = 0, ofs_index = 0, sp_val = 0;
  logic [2:0]  ilen = 0;
  logic        ip_adv = 0;
  logic [19:0] phys_addr;
  logic [15:0] ip_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_seg [4];
  logic [15:0] m_ip;

  always #5 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .seg_we(seg_we), .seg_sel(seg_sel),
    .seg_wdata(seg_wdata), .acc_type(acc_type), .ofs_src(ofs_src),
    .ofs_direct(ofs_direct), .ofs_index(ofs_index), .sp_val(sp_val),
    .ilen(ilen), .ip_adv(ip_adv), .phys_addr(phys_addr), .ip_out(ip_out));

  function automatic logic [19:0] map(input logic [15:0] s, input logic [15:0] o);
    return ({4'b0, s} << 4) + {4'b0, o};
  endfunction

  function automatic logic [19:0] exp_addr();
    logic [15:0] o;
    case (acc_type)
      2'd0: o = m_ip;
      2'd2: o = sp_val;
      default: o = (ofs_src == 2'd0) ? ofs_direct : (ofs_src == 2'd1) ? ofs_index : sp_val;
    endcase
    return map(m_seg[acc_type], o);
  endfunction

  function automatic string req_of();
    case (acc_type)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [19:0] got, input logic [19:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %05h expected %05h", req, got, exp);
    end
  endtask

  task automatic check_now();
    #1;
    chk(req_of(), phys_addr, exp_addr());
    chk("R7/R8", {4'b0, ip_out}, {4'b0, m_ip});
  endtask

  task automatic step();
    @(posedge clk);
    if (seg_we) m_seg[seg_sel] = seg_wdata;
    if (ip_adv) m_ip = m_ip + 16'(ilen);
    @(negedge clk);
  endtask

  task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
    seg_we = 1; seg_sel = s; seg_wdata = v; ip_adv = 0;
    step();
    seg_we = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    m_seg[0] = 16'hFFFF; m_seg[1] = 0; m_seg[2] = 0; m_seg[3] = 0; m_ip = 0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    acc_type = 0; #1;
    chk("R1", phys_addr, 20'hFFFF0);
    chk("R1", {4'b0, ip_out}, 20'h0);
    rst_n = 1;
    @(negedge clk);
    // R1: the first fetch address after release
    acc_type = 0; check_now();
    chk("R1", phys_addr, 20'hFFFF0);
    acc_type = 1; ofs_src = 0; ofs_direct = 16'h0000; #1;
    chk("R1", phys_addr, 20'h00000);
    acc_type = 2; sp_val = 0; #1;
    chk("R1", phys_addr, 20'h00000);
    acc_type = 3; #1;
    chk("R1", phys_addr, 20'h00000);

    // R2/R7: reach IP 0012, then fetch at 1234:0012
    wr_seg(0, 16'h1234);
    ip_adv = 1; ilen = 6; step(); step(); step(); ip_adv = 0;
    acc_type = 0; #1;
    chk("R2", phys_addr, 20'h12352);
    ip_adv = 1; ilen = 2; step(); ip_adv = 0; #1;
    chk("R7", {4'b0, ip_out}, 20'h00014);
    // R8: IP holds with no advance strobe
    ilen = 7; step(); #1;
    chk("R8", {4'b0, ip_out}, 20'h00014);

    // R3: data base with a direct offset and with an index offset
    wr_seg(1, 16'h1234);
    acc_type = 1; ofs_src = 0; ofs_direct = 16'h0300; #1;
    chk("R3", phys_addr, 20'h12640);
    ofs_src = 1; ofs_index = 16'h0310; #1;
    chk("R3", phys_addr, 20'h12650);
    ofs_src = 3; sp_val = 16'h0008; #1;
    chk("R3", phys_addr, 20'h12348);

    // R4: the stack access ignores ofs_src
    wr_seg(2, 16'h5000);
    acc_type = 2; ofs_src = 0; ofs_direct = 16'h1111; sp_val = 16'hFFE0; #1;
    chk("R4", phys_addr, 20'h5FFE0);

    // R5, R6: extra base, and wrap of the address sum
    wr_seg(3, 16'hFFFF);
    acc_type = 3; ofs_src = 0; ofs_direct = 16'hFFFF; #1;
    chk("R6", phys_addr, 20'h0FFEF);
    ofs_src = 1; ofs_index = 16'h0010; #1;
    chk("R5", phys_addr, 20'h00000);

    // R9: a write to one base leaves the others unchanged
    wr_seg(1, 16'hABCD);
    acc_type = 3; ofs_src = 1; ofs_index = 0; #1;
    chk("R9", phys_addr, 20'hFFFF0);
    acc_type = 2; sp_val = 0; #1;
    chk("R9", phys_addr, 20'h50000);

    // R7: IP wraps modulo 2^16
    ip_adv = 1; ilen = 7;
    while (m_ip < 16'hFFF9) step();
    step(); ip_adv = 0; #1;
    chk("R7", {4'b0, ip_out}, {4'b0, m_ip});
    chk("R7", {4'b0, ip_out < 16'h0008}, 20'h1);

    // Random mix across all access types and offset sources
    for (int i = 0; i < 20000; i++) begin
      seg_we     = ($urandom_range(3) == 0);
      seg_sel    = 2'($urandom);
      seg_wdata  = 16'($urandom);
      acc_type   = 2'($urandom);
      ofs_src    = 2'($urandom);
      ofs_direct = 16'($urandom);
      ofs_index  = 16'($urandom);
      sp_val     = 16'($urandom);
      ilen       = 3'($urandom);
      ip_adv     = 1'($urandom);
      check_now();
      step();
    end
    check_now();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule